// File: doc/BRIEF.md
# Order Entry Message Serializer

This block takes one parallel order request at a time and streams it to the exchange link as a message of fixed layout, one byte per clock under a valid/ready handshake. A two-bit kind selects one of three messages: a new order, a cancel of an earlier order, or a modify of the price and quantity of an earlier order. Each message opens with an ASCII type character, and every multi-byte field goes out most significant byte first.

For a new order the block issues the order identifier itself, from a counter that steps only on new orders. It also stamps the order with the value of a free-running cycle counter. The symbol is sent as exactly six characters: the requester gives a length, and the positions past that length go out as spaces. The requester holds its inputs steady while `req_valid` is high, until `req_ready` accepts them. The output stream marks the first byte with a start flag and the last byte with an end flag.

Top module: `ord_msg_ser`

## Requirements
- R1: A new order (kind 0) is 37 bytes: 0x4F, the 8-byte order ID, the 8-byte timestamp, the 6-byte symbol, the side byte, the 8-byte price, the 4-byte quantity, then the time-in-force byte, with every multi-byte field most significant byte first.
- R2: The side byte is 0x42 when `req_sell` is 0 and 0x53 when `req_sell` is 1.
- R3: Symbol character i (i = 0 to 5, character 0 in `req_sym[47:40]`) is sent as given when i < `req_sym_len`, otherwise as 0x20; a length of 6 or more sends all six characters.
- R4: A cancel (kind 1) is 9 bytes: 0x58, then the 8-byte `req_ref_id`.
- R5: A modify (kind 2) is 21 bytes: 0x55, the 8-byte `req_ref_id`, the 8-byte `req_price`, then the 4-byte `req_qty`.
- R6: The first new order after reset carries ID 1, and each later new order carries the previous ID plus one; cancels, modifies and kind 3 requests use no ID.
- R7: The timestamp of a new order equals the number of rising clock edges since reset was released, counted up to but not including the edge that accepts the order.
- R8: `out_sop` is high on the first byte of each message only, and `out_eop` on the last byte only; `out_valid` is low in the cycle after the last byte is taken.
- R9: After reset `out_valid` is low and `req_ready` is high; `req_ready` is low from the cycle after acceptance of a message until its last byte has been taken.
- R10: While `out_valid` is high and `out_ready` is low, the byte and both markers stay unchanged on the next cycle.
- R11: A kind 3 request is accepted and discarded: no byte is sent and `req_ready` stays high.
- R12: Reset in the middle of a message drops it at once: `out_valid` falls, and the ID and timestamp counters restart.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted on this edge when valid is high |
| req_kind | input | 2 | 0 new order, 1 cancel, 2 modify, 3 discarded |
| req_ref_id | input | 64 | Identifier of the earlier order for cancel and modify |
| req_sym | input | 48 | Six symbol characters, first in the top byte |
| req_sym_len | input | 4 | Number of valid symbol characters |
| req_sell | input | 1 | Side: 0 buy, 1 sell |
| req_price | input | 64 | Price |
| req_qty | input | 32 | Quantity |
| req_tif | input | 8 | Time-in-force code |
| out_valid | output | 1 | Byte present on out_data |
| out_ready | input | 1 | Link takes the byte on this edge |
| out_data | output | 8 | Message byte |
| out_sop | output | 1 | First byte of a message |
| out_eop | output | 1 | Last byte of a message |

## Verification
The first byte of a message is on the output in the cycle after the edge that accepts the request. Each further byte appears one edge after the previous one is taken with `out_ready` high, and `req_ready` returns one cycle after the edge that takes the last byte. The bench drives and samples only on falling edges. It counts an output byte as taken only when it saw `out_ready` high in that same half-cycle, and it checks that `req_ready` has dropped one time unit after the accepting edge. For the timestamp it keeps its own count of rising edges since reset release, and takes as the expected value that count at the falling edge just before the accepting edge.

// File: rtl/ord_msg_pkg.sv
package ord_msg_pkg;
  typedef enum logic [1:0] {
    KIND_NEW    = 2'd0,
    KIND_CANCEL = 2'd1,
    KIND_MODIFY = 2'd2,
    KIND_NONE   = 2'd3
  } ord_kind_e;

  localparam logic [7:0] TYPE_NEW    = 8'h4F;
  localparam logic [7:0] TYPE_CANCEL = 8'h58;
  localparam logic [7:0] TYPE_MODIFY = 8'h55;
  localparam logic [7:0] SIDE_BUY    = 8'h42;
  localparam logic [7:0] SIDE_SELL   = 8'h53;
  localparam logic [7:0] CHAR_SPACE  = 8'h20;
endpackage

// File: rtl/ord_stamp_gen.sv
module ord_stamp_gen #(
  parameter int ID_W = 64,
  parameter int TS_W = 64
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            take_id,
  output logic [ID_W-1:0] next_id,
  output logic [TS_W-1:0] stamp
);
  logic [ID_W-1:0] id_q, id_d;
  logic [TS_W-1:0] ts_q, ts_d;

  always_comb begin
    id_d = id_q;
    if (take_id) id_d = id_q + ID_W'(1);
    ts_d = ts_q + TS_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      id_q <= '0;
      ts_q <= '0;
    end else begin
      id_q <= id_d;
      ts_q <= ts_d;
    end
  end

  assign next_id = id_q + ID_W'(1);
  assign stamp   = ts_q;

  // R6
  id_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take_id |=> (id_q == $past(id_q) + ID_W'(1)));
  // R6
  id_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !take_id |=> $stable(id_q));
endmodule

// File: rtl/ord_frame_pack.sv
module ord_frame_pack
  import ord_msg_pkg::*;
#(
  parameter int ID_W      = 64,
  parameter int TS_W      = 64,
  parameter int PRICE_W   = 64,
  parameter int QTY_W     = 32,
  parameter int SYM_CHARS = 6,
  parameter int SLEN_W    = 4,
  parameter int FRAME_W   = 8 + ID_W + TS_W + 8*SYM_CHARS + 8 + PRICE_W + QTY_W + 8,
  parameter int IDX_W     = $clog2(FRAME_W/8)
) (
  input  logic [1:0]             kind,
  input  logic [ID_W-1:0]        ref_id,
  input  logic [8*SYM_CHARS-1:0] sym,
  input  logic [SLEN_W-1:0]      sym_len,
  input  logic                   sell,
  input  logic [PRICE_W-1:0]     price,
  input  logic [QTY_W-1:0]       qty,
  input  logic [7:0]             tif,
  input  logic [ID_W-1:0]        new_id,
  input  logic [TS_W-1:0]        stamp,
  output logic [FRAME_W-1:0]     frame,
  output logic [IDX_W-1:0]       last_idx,
  output logic                   has_msg
);
  localparam int CXL_W = 8 + ID_W;
  localparam int MOD_W = 8 + ID_W + PRICE_W + QTY_W;

  logic [8*SYM_CHARS-1:0] sym_pad;

  for (genvar g = 0; g < SYM_CHARS; g++) begin : g_sym
    assign sym_pad[8*(SYM_CHARS-g)-1 -: 8] =
      (SLEN_W'(g) < sym_len) ? sym[8*(SYM_CHARS-g)-1 -: 8] : CHAR_SPACE;
  end

  always_comb begin
    frame    = '0;
    last_idx = '0;
    has_msg  = 1'b1;
    unique case (ord_kind_e'(kind))
      KIND_NEW: begin
        frame    = {TYPE_NEW, new_id, stamp, sym_pad,
                    (sell ? SIDE_SELL : SIDE_BUY), price, qty, tif};
        last_idx = IDX_W'(FRAME_W/8 - 1);
      end
      KIND_CANCEL: begin
        frame    = {TYPE_CANCEL, ref_id, {(FRAME_W-CXL_W){1'b0}}};
        last_idx = IDX_W'(CXL_W/8 - 1);
      end
      KIND_MODIFY: begin
        frame    = {TYPE_MODIFY, ref_id, price, qty, {(FRAME_W-MOD_W){1'b0}}};
        last_idx = IDX_W'(MOD_W/8 - 1);
      end
      default: has_msg = 1'b0;
    endcase
  end
endmodule

// File: rtl/ord_byte_shifter.sv
module ord_byte_shifter #(
  parameter int FRAME_W = 296,
  parameter int IDX_W   = 6
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load,
  input  logic [FRAME_W-1:0] frame_in,
  input  logic [IDX_W-1:0]   last_in,
  input  logic               out_ready,
  output logic               busy,
  output logic [7:0]         out_data,
  output logic               out_sop,
  output logic               out_eop
);
  logic               busy_q, busy_d;
  logic [FRAME_W-1:0] sh_q, sh_d;
  logic [IDX_W-1:0]   idx_q, idx_d;
  logic [IDX_W-1:0]   last_q, last_d;
  logic               at_end;

  assign at_end = (idx_q == last_q);

  always_comb begin
    busy_d = busy_q;
    sh_d   = sh_q;
    idx_d  = idx_q;
    last_d = last_q;
    if (load) begin
      busy_d = 1'b1;
      sh_d   = frame_in;
      idx_d  = '0;
      last_d = last_in;
    end else if (busy_q && out_ready) begin
      if (at_end) begin
        busy_d = 1'b0;
      end else begin
        sh_d  = sh_q << 8;
        idx_d = idx_q + IDX_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      sh_q   <= '0;
      idx_q  <= '0;
      last_q <= '0;
    end else begin
      busy_q <= busy_d;
      sh_q   <= sh_d;
      idx_q  <= idx_d;
      last_q <= last_d;
    end
  end

  assign busy     = busy_q;
  assign out_data = sh_q[FRAME_W-1 -: 8];
  assign out_sop  = busy_q && (idx_q == '0);
  assign out_eop  = busy_q && at_end;

  // R10
  hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !out_ready) |=> (busy && $stable(out_data) && $stable(out_sop) && $stable(out_eop)));
  // R8
  eop_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && out_ready && out_eop) |=> !busy);
endmodule

// File: rtl/ord_msg_ser.sv
module ord_msg_ser
  import ord_msg_pkg::*;
#(
  parameter int ID_W      = 64,
  parameter int TS_W      = 64,
  parameter int PRICE_W   = 64,
  parameter int QTY_W     = 32,
  parameter int SYM_CHARS = 6,
  parameter int SLEN_W    = 4
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   req_valid,
  output logic                   req_ready,
  input  logic [1:0]             req_kind,
  input  logic [ID_W-1:0]        req_ref_id,
  input  logic [8*SYM_CHARS-1:0] req_sym,
  input  logic [SLEN_W-1:0]      req_sym_len,
  input  logic                   req_sell,
  input  logic [PRICE_W-1:0]     req_price,
  input  logic [QTY_W-1:0]       req_qty,
  input  logic [7:0]             req_tif,
  output logic                   out_valid,
  input  logic                   out_ready,
  output logic [7:0]             out_data,
  output logic                   out_sop,
  output logic                   out_eop
);
  localparam int FRAME_W = 8 + ID_W + TS_W + 8*SYM_CHARS + 8 + PRICE_W + QTY_W + 8;
  localparam int IDX_W   = $clog2(FRAME_W/8);

  logic               busy, accept, load, take_id, has_msg;
  logic [ID_W-1:0]    next_id;
  logic [TS_W-1:0]    stamp;
  logic [FRAME_W-1:0] frame;
  logic [IDX_W-1:0]   last_idx;

  assign req_ready = !busy;
  assign accept    = req_valid && req_ready;
  assign load      = accept && has_msg;
  assign take_id   = accept && (ord_kind_e'(req_kind) == KIND_NEW);
  assign out_valid = busy;

  ord_stamp_gen #(.ID_W(ID_W), .TS_W(TS_W)) u_stamp (
    .clk(clk), .rst_n(rst_n), .take_id(take_id),
    .next_id(next_id), .stamp(stamp)
  );

  ord_frame_pack #(
    .ID_W(ID_W), .TS_W(TS_W), .PRICE_W(PRICE_W), .QTY_W(QTY_W),
    .SYM_CHARS(SYM_CHARS), .SLEN_W(SLEN_W), .FRAME_W(FRAME_W), .IDX_W(IDX_W)
  ) u_pack (
    .kind(req_kind), .ref_id(req_ref_id), .sym(req_sym), .sym_len(req_sym_len),
    .sell(req_sell), .price(req_price), .qty(req_qty), .tif(req_tif),
    .new_id(next_id), .stamp(stamp),
    .frame(frame), .last_idx(last_idx), .has_msg(has_msg)
  );

  ord_byte_shifter #(.FRAME_W(FRAME_W), .IDX_W(IDX_W)) u_shift (
    .clk(clk), .rst_n(rst_n), .load(load), .frame_in(frame), .last_in(last_idx),
    .out_ready(out_ready), .busy(busy), .out_data(out_data),
    .out_sop(out_sop), .out_eop(out_eop)
  );

  // R9
  load_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (out_valid && out_sop && !req_ready));
  // R11
  none_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !has_msg) |=> (!out_valid && req_ready));
  // R8
  sop_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready && !out_eop) |=> !out_sop);
endmodule

// File: tb/ord_msg_ser_tb.sv
module ord_msg_ser_tb;
  typedef struct packed {
    logic [1:0]  kind;
    logic        sell;
    logic [63:0] rid;
    logic [47:0] sym;
    logic [3:0]  slen;
    logic [63:0] price;
    logic [31:0] qty;
    logic [7:0]  tif;
    logic        stall;
  } vec_t;

  localparam int NV = 7;
  localparam vec_t VEC [NV] = '{
    '{2'd0, 1'b0, 64'd0, 48'h414243_000000, 4'd3, 64'h0000_0000_0001_86A0, 32'd100, 8'h30, 1'b0},
    '{2'd1, 1'b0, 64'h0000_0000_0000_0001, 48'h0, 4'd0, 64'h0, 32'h0, 8'h0, 1'b1},
    '{2'd2, 1'b1, 64'h1122_3344_5566_7788, 48'h0, 4'd0, 64'hA1A2_A3A4_A5A6_A7A8, 32'hB1B2_B3B4, 8'h0, 1'b1},
    '{2'd0, 1'b1, 64'd0, 48'h5A51_5745_5254, 4'd9, 64'h0102_0304_0506_0708, 32'h0A0B_0C0D, 8'h33, 1'b1},
    '{2'd0, 1'b0, 64'd0, 48'h4142_4344_4546, 4'd0, 64'hFFFF_FFFF_FFFF_FFFF, 32'hFFFF_FFFF, 8'hFF, 1'b0},
    '{2'd1, 1'b0, 64'hFFFF_FFFF_FFFF_FFFF, 48'h0, 4'd0, 64'h0, 32'h0, 8'h0, 1'b0},
    '{2'd0, 1'b1, 64'd0, 48'h4D4E_4F50_5152, 4'd6, 64'h0000_0000_0000_0001, 32'd1, 8'h31, 1'b1}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [1:0]  req_kind = 2'd0;
  logic [63:0] req_ref_id = '0;
  logic [47:0] req_sym = '0;
  logic [3:0]  req_sym_len = '0;
  logic        req_sell = 1'b0;
  logic [63:0] req_price = '0;
  logic [31:0] req_qty = '0;
  logic [7:0]  req_tif = '0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [7:0]  out_data;
  logic        out_sop, out_eop;

  int checks = 0;
  int fails = 0;
  longint edge_cnt = 0;
  longint exp_id = 0;
  longint exp_ts = 0;

  always #4 clk = ~clk;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) edge_cnt <= 0;
    else        edge_cnt <= edge_cnt + 1;
  end

  ord_msg_ser u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_kind(req_kind), .req_ref_id(req_ref_id), .req_sym(req_sym),
    .req_sym_len(req_sym_len), .req_sell(req_sell), .req_price(req_price),
    .req_qty(req_qty), .req_tif(req_tif), .out_valid(out_valid),
    .out_ready(out_ready), .out_data(out_data), .out_sop(out_sop), .out_eop(out_eop)
  );

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [295:0] expect_frame(input vec_t v, input longint id,
                                                input longint ts, output int len);
    logic [47:0] s;
    for (int i = 0; i < 6; i++)
      s[47-8*i -: 8] = (i < int'(v.slen)) ? v.sym[47-8*i -: 8] : 8'h20;
    case (v.kind)
      2'd0: begin
        len = 37;
        return {8'h4F, 64'(id), 64'(ts), s, (v.sell ? 8'h53 : 8'h42), v.price, v.qty, v.tif};
      end
      2'd1: begin
        len = 9;
        return {8'h58, v.rid, 224'h0};
      end
      default: begin
        len = 21;
        return {8'h55, v.rid, v.price, v.qty, 128'h0};
      end
    endcase
  endfunction

  task automatic send(input vec_t v);
    @(negedge clk);
    req_kind = v.kind; req_ref_id = v.rid; req_sym = v.sym; req_sym_len = v.slen;
    req_sell = v.sell; req_price = v.price; req_qty = v.qty; req_tif = v.tif;
    req_valid = 1'b1;
    check(req_ready === 1'b1, "R9 ready when idle", longint'(req_ready), 1);
    exp_ts = edge_cnt;
    if (v.kind == 2'd0) exp_id++;
    @(posedge clk);
    #1;
    if (v.kind != 2'd3)
      check(req_ready === 1'b0, "R9 ready low while busy", longint'(req_ready), 0);
  endtask

  task automatic run_msg(input vec_t v, input string tag);
    int len;
    logic [295:0] f;
    int n = 0, cyc = 0, data_bad = 0, mark_bad = 0, hold_bad = 0;
    logic [7:0] held = '0;
    logic held_sop = 1'b0, held_eop = 1'b0;
    bit was_stall = 0;
    longint first_act = -1, first_exp = -1;
    f = expect_frame(v, exp_id, exp_ts, len);
    while (n < len && cyc < 400) begin
      @(negedge clk);
      req_valid = 1'b0;
      if (was_stall && (out_data !== held || out_sop !== held_sop || out_eop !== held_eop))
        hold_bad++;
      out_ready = !(v.stall && (cyc % 3 == 1));
      cyc++;
      was_stall = 0;
      if (out_valid !== 1'b1) begin
        data_bad++;
      end else if (out_ready) begin
        if (out_data !== f[295-8*n -: 8]) begin
          if (first_act < 0) begin
            first_act = longint'(out_data); first_exp = longint'(f[295-8*n -: 8]);
          end
          data_bad++;
        end
        if (out_sop !== (n == 0) || out_eop !== (n == len-1)) mark_bad++;
        n++;
      end else begin
        held = out_data; held_sop = out_sop; held_eop = out_eop; was_stall = 1;
      end
    end
    out_ready = 1'b1;
    check(data_bad == 0 && n == len, {tag, " bytes"}, first_act, first_exp);
    check(n == len, {tag, " length"}, longint'(n), longint'(len));
    check(mark_bad == 0, "R8 start/end markers", longint'(mark_bad), 0);
    if (v.stall) check(hold_bad == 0, "R10 held while stalled", longint'(hold_bad), 0);
    @(negedge clk);
    check(out_valid === 1'b0 && req_ready === 1'b1, "R8 idle after end",
          longint'(out_valid), 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", checks, 0);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    vec_t nv;
    repeat (3) @(negedge clk);
    check(out_valid === 1'b0, "R9 reset out_valid", longint'(out_valid), 0);
    check(req_ready === 1'b1, "R9 reset req_ready", longint'(req_ready), 1);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      string tag;
      case (VEC[i].kind)
        2'd0: tag = "R1/R2/R3/R6/R7 new order";
        2'd1: tag = "R4 cancel";
        default: tag = "R5 modify";
      endcase
      send(VEC[i]);
      run_msg(VEC[i], tag);
    end

    // R11: kind 3 accepted, no output, no ID used
    nv = VEC[0];
    nv.kind = 2'd3;
    send(nv);
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      req_valid = 1'b0;
      check(out_valid === 1'b0 && req_ready === 1'b1, "R11 kind 3 discarded",
            longint'(out_valid), 0);
    end
    send(VEC[0]);
    run_msg(VEC[0], "R6/R11 ID after discarded request");

    // R12: reset in the middle of a message
    send(VEC[3]);
    repeat (5) @(negedge clk);
    req_valid = 1'b0;
    rst_n = 1'b0;
    #1;
    check(out_valid === 1'b0, "R12 reset drops message", longint'(out_valid), 0);
    check(req_ready === 1'b1, "R12 ready after reset", longint'(req_ready), 1);
    @(negedge clk);
    rst_n = 1'b1;
    exp_id = 0;
    repeat (3) @(negedge clk);
    send(VEC[6]);
    run_msg(VEC[6], "R12/R6/R7 counters restart");

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule